// File: doc/BRIEF.md
# Burst SPI Master Controller

This block is a register-mapped SPI master. Software loads 32-bit words into a transmit queue, programs a burst length in bits (1 to 4096), picks one of four chip selects and starts the burst by writing the exchange bit. The shift engine moves every bit out on MOSI and samples MISO, most significant bit first. It packs the received bits into 32-bit words in a receive queue, and raises a completion flag when the last bit has been shifted.

Each chip select has its own clock phase, clock polarity, idle clock level and select polarity, kept in a config register. The serial clock comes from a two-stage divider: a 4-bit linear pre-divider followed by a 4-bit power-of-two post-divider. When the burst length is not a multiple of 32, only the low (length mod 32) bits of the first word are shifted, and every following word is shifted in full. Clearing the enable bit aborts any burst and empties both queues.

The bus is a simple word-wide interface with a one-cycle write and a combinational read. Reading the receive data register pops a word. Word addresses: 0 receive data, 1 transmit data, 2 control, 3 config, 4 status.

Top module: `spi_burst_master`

## Requirements
- R1: The control register stores enable (bit 0), master (bit 1), per-select mode bits (7:4), post divider (11:8), pre divider (15:12), chip select (19:18) and burst length minus one (31:20), and these bits read back as written. Bit 2 reads 1 while a burst is running and returns to 0 by itself when the burst ends.
- R2: Writing the transmit data register never starts a burst. A burst starts only when the control register is written with bits 0 and 2 set while the block is already enabled and idle. Until then all chip selects stay inactive.
- R3: One serial clock period spans 2·(pre+1)·2^post system clock cycles. The done flag becomes visible exactly 2·length·(pre+1)·2^post cycles after the starting write.
- R4: When the burst length is not a multiple of 32, the first transmit word contributes only its low (length mod 32) bits. All bits leave on MOSI most significant bit first.
- R5: For the selected chip select, config bit 0+cs is the clock phase and bit 4+cs is the clock polarity. With phase 0, data is sampled on the edge that leaves the polarity level. With phase 1, data is sampled on the edge that returns to it. Exactly one sampling edge occurs per bit.
- R6: Config bit 12+cs is the active level of select cs. Only the selected output takes that level during a burst, and every select sits at its inverse otherwise. While no burst runs, the serial clock sits at config bit 20+cs of the chip select in the control register.
- R7: Received bits are packed with the same alignment as transmitted ones: a partial first word is right-aligned, and later words are full.
- R8: A received word that finds the receive queue full is dropped and sets status bit 6. Writing 1 to status bit 7 or bit 6 clears that bit.
- R9: If the transmit queue runs empty during a burst, the engine shifts zeros.
- R10: Clearing the enable bit empties both queues and stops the engine.
- R11: Each queue holds 8 words, so a 256-bit burst can be queued in full before the start.
- R12: Status bit 7 is set when the burst ends and stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | 4 | Chip select outputs, level per select polarity |

## Verification
A wrong internal state shows up at the ports within one burst. A bad bit or word count moves the done flag away from its exact cycle. A bad alignment or phase changes the bits that an edge monitor captures on MOSI and the words read back through the loopback. A stuck queue pointer or a missed flush returns stale or missing words on the first receive read after the burst. Because every burst in the bench is timed to the exact cycle, a divider or phase counter that slips even one tick is reported against the burst that exposed it.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
    localparam int WORD_W = 32;
    localparam int CS_N   = 4;
    localparam int CS_W   = 2;

    typedef enum logic [2:0] {
        ADDR_RXD  = 3'd0,
        ADDR_TXD  = 3'd1,
        ADDR_CTRL = 3'd2,
        ADDR_CFG  = 3'd3,
        ADDR_STAT = 3'd4
    } reg_addr_e;

    // control fields
    localparam int CTRL_EN_B    = 0;
    localparam int CTRL_XCH_B   = 2;
    localparam int CTRL_POST_LO = 8;
    localparam int CTRL_PRE_LO  = 12;
    localparam int CTRL_CS_LO   = 18;
    localparam int CTRL_LEN_LO  = 20;
    localparam logic [31:0] CTRL_KEEP = 32'hFFFC_FFF3;

    // per-select config offsets
    localparam int CFG_PHA_OFS   = 0;
    localparam int CFG_POL_OFS   = 4;
    localparam int CFG_SSPOL_OFS = 12;
    localparam int CFG_IDLE_OFS  = 20;
    localparam logic [31:0] CFG_KEEP = 32'h00F0_F0FF;

    // status bits
    localparam int STAT_DONE_B = 7;
    localparam int STAT_OVF_B  = 6;
endpackage

// File: rtl/sbm_fifo.sv
`timescale 1ns/1ps
module sbm_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign rdata = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = wdata;
                d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            end
            if (do_pop) begin
                d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            end
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11: occupancy never exceeds the configured depth
    assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/sbm_clkdiv.sv
`timescale 1ns/1ps
module sbm_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] pre,
    input  logic [DIV_W-1:0] post,
    output logic             tick
);
    localparam int CNT_W = DIV_W + (1 << DIV_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             q, d;
    logic [CNT_W-1:0] span;

    always_comb begin
        span = (CNT_W'(pre) + 1'b1) << post;
        tick = run && (q.cnt == span - 1'b1);
        d    = q;
        if (!run || tick) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: the count stays inside one half period
    assert_div_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt < span));
endmodule

// File: rtl/sbm_shifter.sv
`timescale 1ns/1ps
module sbm_shifter #(
    parameter int LEN_W  = 12,
    parameter int WORD_W = 32,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [CS_W-1:0]   cs_i,
    input  logic              cpha_i,
    input  logic              cpol_i,
    input  logic              tick,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              miso,
    output logic              mosi,
    output logic              sclk,
    output logic              busy,
    output logic [CS_W-1:0]   cs_o,
    output logic              done
);
    localparam int BC_W  = $clog2(WORD_W + 1);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int REM_W = LEN_W + 1;

    typedef struct packed {
        logic              busy;
        logic              half;
        logic              first;
        logic              sclk;
        logic              cpha;
        logic              cpol;
        logic [CS_W-1:0]   cs;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] rsr;
        logic [BC_W-1:0]   tx_left;
        logic [BC_W-1:0]   rx_cnt;
        logic [BC_W-1:0]   rx_size;
        logic [REM_W-1:0]  rem;
    } eng_t;

    eng_t              q, d;
    logic              sample, shift;
    logic [REM_W-1:0]  rem_after;
    logic [WORD_W-1:0] fetched;
    logic [BC_W-1:0]   nb;

    assign mosi    = q.sr[WORD_W-1];
    assign sclk    = q.sclk;
    assign busy    = q.busy;
    assign cs_o    = q.cs;
    assign rx_word = {q.rsr[WORD_W-2:0], miso};

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        done      = 1'b0;
        sample    = 1'b0;
        shift     = 1'b0;
        rem_after = q.rem;
        fetched   = tx_empty ? '0 : tx_data;
        nb        = BC_W'(len_m1[IDX_W-1:0]) + 1'b1;
        if (flush) begin
            d = '0;
        end else if (!q.busy) begin
            if (start) begin
                tx_pop    = !tx_empty;
                d.busy    = 1'b1;
                d.half    = 1'b0;
                d.first   = 1'b1;
                d.sclk    = cpol_i;
                d.cpol    = cpol_i;
                d.cpha    = cpha_i;
                d.cs      = cs_i;
                d.sr      = fetched << (WORD_W - int'(nb));
                d.tx_left = nb;
                d.rx_size = nb;
                d.rx_cnt  = '0;
                d.rsr     = '0;
                d.rem     = REM_W'(len_m1) + 1'b1;
            end
        end else if (tick) begin
            d.sclk = ~q.sclk;
            d.half = ~q.half;
            sample = (q.half == q.cpha);
            if (sample) begin
                rem_after = q.rem - 1'b1;
                d.rem     = rem_after;
                if (q.rx_cnt + 1'b1 == q.rx_size) begin
                    rx_push   = 1'b1;
                    d.rx_cnt  = '0;
                    d.rsr     = '0;
                    d.rx_size = BC_W'(WORD_W);
                end else begin
                    d.rx_cnt = q.rx_cnt + 1'b1;
                    d.rsr    = {q.rsr[WORD_W-2:0], miso};
                end
            end
            if (!q.half) d.first = 1'b0;
            shift = q.cpha ? (!q.half && !q.first)
                           : (q.half && rem_after != '0);
            if (shift) begin
                if (q.tx_left == BC_W'(1)) begin
                    tx_pop    = !tx_empty;
                    d.sr      = fetched;
                    d.tx_left = BC_W'(WORD_W);
                end else begin
                    d.sr      = q.sr << 1;
                    d.tx_left = q.tx_left - 1'b1;
                end
            end
            if (q.half && rem_after == '0) begin
                done   = 1'b1;
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12: completion ends the burst on the next edge
    assert_done_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.busy);
    // R2: the transmit queue is drained only by a running or starting burst
    assert_pop_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (q.busy || start));
    // R3: the serial clock moves only on divider ticks
    assert_sclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick && !flush) |=> $stable(q.sclk));
    // R5: a burst begins at the polarity level
    assert_start_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !q.busy && !flush) |=> (q.sclk == q.cpol));
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 4,
    parameter int LEN_W      = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_ss
);
    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] cfg;
        logic        done;
        logic        ovf;
    } regs_t;

    regs_t q, d;

    logic              wr_ctrl, wr_cfg, wr_stat, wr_tx, rd_rx, start, flush;
    logic [CS_W-1:0]   start_cs, ctrl_cs, eng_cs;
    logic              tx_empty, tx_full, tx_pop;
    logic              rx_empty, rx_full, rx_push;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              tick, eng_busy, eng_done, eng_sclk;

    assign wr_ctrl  = bus_en && bus_we && (bus_addr == ADDR_CTRL);
    assign wr_cfg   = bus_en && bus_we && (bus_addr == ADDR_CFG);
    assign wr_stat  = bus_en && bus_we && (bus_addr == ADDR_STAT);
    assign wr_tx    = bus_en && bus_we && (bus_addr == ADDR_TXD);
    assign rd_rx    = bus_en && !bus_we && (bus_addr == ADDR_RXD);
    assign flush    = !q.ctrl[CTRL_EN_B];
    assign start    = wr_ctrl && q.ctrl[CTRL_EN_B] && bus_wdata[CTRL_EN_B]
                      && bus_wdata[CTRL_XCH_B] && !eng_busy;
    assign start_cs = bus_wdata[CTRL_CS_LO +: CS_W];
    assign ctrl_cs  = q.ctrl[CTRL_CS_LO +: CS_W];

    always_comb begin
        d = q;
        if (wr_ctrl) d.ctrl = bus_wdata & CTRL_KEEP;
        if (wr_cfg)  d.cfg  = bus_wdata & CFG_KEEP;
        if (wr_stat) begin
            if (bus_wdata[STAT_DONE_B]) d.done = 1'b0;
            if (bus_wdata[STAT_OVF_B])  d.ovf  = 1'b0;
        end
        if (eng_done)               d.done = 1'b1;
        if (rx_push && rx_full)     d.ovf  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            ADDR_CTRL: bus_rdata = q.ctrl | (32'(eng_busy) << CTRL_XCH_B);
            ADDR_CFG:  bus_rdata = q.cfg;
            ADDR_STAT: bus_rdata = (32'(q.done) << STAT_DONE_B)
                                 | (32'(q.ovf) << STAT_OVF_B);
            default:   bus_rdata = '0;
        endcase
    end

    sbm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr_tx), .wdata(bus_wdata), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    sbm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .wdata(rx_word), .pop(rd_rx),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    sbm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy),
        .pre(q.ctrl[CTRL_PRE_LO +: DIV_W]),
        .post(q.ctrl[CTRL_POST_LO +: DIV_W]),
        .tick(tick)
    );

    sbm_shifter #(.LEN_W(LEN_W), .WORD_W(WORD_W), .CS_W(CS_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
        .len_m1(bus_wdata[CTRL_LEN_LO +: LEN_W]),
        .cs_i(start_cs),
        .cpha_i(q.cfg[CFG_PHA_OFS + int'(start_cs)]),
        .cpol_i(q.cfg[CFG_POL_OFS + int'(start_cs)]),
        .tick(tick),
        .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .miso(spi_miso), .mosi(spi_mosi), .sclk(eng_sclk),
        .busy(eng_busy), .cs_o(eng_cs), .done(eng_done)
    );

    assign spi_sclk = eng_busy ? eng_sclk : q.cfg[CFG_IDLE_OFS + int'(ctrl_cs)];

    for (genvar i = 0; i < CS_N; i++) begin : g_sel
        assign spi_ss[i] = (eng_busy && eng_cs == CS_W'(i))
                           ? q.cfg[CFG_SSPOL_OFS + i] : ~q.cfg[CFG_SSPOL_OFS + i];
    end

    // R8: the overflow flag rises only on a push into a full receive queue
    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(rx_push && rx_full));
    // R6: at most one select differs from its inactive level
    assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spi_ss ^ ~q.cfg[CFG_SSPOL_OFS +: CS_N]) <= 1);
    // R10: a disabled block runs no burst
    assert_flush_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !eng_busy);
endmodule

// File: tb/sim_spi_burst_master.sv
`timescale 1ns/1ps
module sim_spi_burst_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_ss;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign spi_miso = spi_mosi;   // loopback

    spi_burst_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss(spi_ss)
    );

    // edge monitor: captures MOSI on the sampling edge
    logic        mon_on = 1'b0, mon_cpha = 1'b0, mon_cpol = 1'b0;
    logic [63:0] mon_bits = 64'd0;
    int          mon_cnt = 0;
    always @(spi_sclk) begin
        if (mon_on && ((spi_sclk != mon_cpol) == (mon_cpha == 1'b0))) begin
            mon_bits = {mon_bits[62:0], spi_mosi};
            mon_cnt++;
        end
    end

    typedef struct packed {
        logic [12:0] len;
        logic [1:0]  cs;
        logic        cpha;
        logic        cpol;
        logic        sspol;
        logic [3:0]  pre;
        logic [3:0]  post;
        logic [31:0] w0;
        logic [31:0] w1;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{13'd8,  2'd0, 1'b0, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0000_00A5, 32'h0},
        '{13'd32, 2'd1, 1'b1, 1'b0, 1'b1, 4'd2,  4'd1, 32'hDEAD_BEEF, 32'h0},
        '{13'd40, 2'd2, 1'b0, 1'b1, 1'b0, 4'd1,  4'd0, 32'h1234_5678, 32'hCAFE_F00D},
        '{13'd13, 2'd3, 1'b1, 1'b1, 1'b1, 4'd0,  4'd2, 32'hFFFF_1ABC, 32'h0},
        '{13'd64, 2'd0, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h8000_0001, 32'h7FFF_FFFE},
        '{13'd1,  2'd2, 1'b0, 1'b0, 1'b1, 4'd15, 4'd0, 32'h0000_0001, 32'h0}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int len, input logic [1:0] cs,
                                              input logic [3:0] pre, input logic [3:0] post,
                                              input logic xch);
        return 32'h3 | (32'(xch) << 2) | (32'(post) << 8) | (32'(pre) << 12)
             | (32'(cs) << 18) | (32'(len - 1) << 20);
    endfunction

    // starts a burst and returns cycles until done is visible
    task automatic burst(input logic [31:0] cw, output int cyc,
                         output logic xch_mid, output logic [3:0] ss_mid);
        logic [31:0] v;
        wr(3'd2, cw);
        @(negedge clk);
        bus_addr = 3'd2;
        #1 xch_mid = bus_rdata[2];
        ss_mid = spi_ss;
        mon_on = 1'b1;
        bus_addr = 3'd4;
        #1 v = bus_rdata;
        cyc = 0;
        while (!v[7] && cyc < 50000) begin
            @(negedge clk);
            #1 v = bus_rdata;
            cyc++;
        end
        mon_on = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        xm;
        logic [3:0]  ssm;
        int          cyc;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state (R1, R6, R12)
        peek(3'd4, v); check("R12 status after reset", 64'(v), 64'h0);
        peek(3'd2, v); check("R1 ctrl after reset", 64'(v), 64'h0);
        check("R6 selects after reset", 64'(spi_ss), 64'hF);
        check("R6 sclk after reset", 64'(spi_sclk), 64'h0);

        // R1 readback without exchange
        wr(3'd2, 32'h7FF8_5A93);
        peek(3'd2, v); check("R1 ctrl readback", 64'(v), 64'h7FF8_5A93);
        wr(3'd3, 32'hFFFF_FFFF);
        peek(3'd3, v); check("R1 cfg readback", 64'(v), 64'h00F0_F0FF);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h3);

        // table of bursts
        for (int i = 0; i < NV; i++) begin
            vec_t        t;
            int          nb, n;
            logic [31:0] m0, cfgv, x0, x1;
            logic [63:0] stream, m64;
            logic [3:0]  idle;
            t  = VECS[i];
            nb = ((int'(t.len) - 1) % 32) + 1;
            m0 = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
            n  = (int'(t.pre) + 1) << t.post;
            cfgv = (32'(t.cpha) << t.cs) | (32'(t.cpol) << (4 + t.cs))
                 | (32'(t.sspol) << (12 + t.cs)) | (32'(t.cpol) << (20 + t.cs));
            idle = 4'hF ^ (4'(t.sspol) << t.cs);
            wr(3'd3, cfgv);
            wr(3'd1, t.w0);
            if (t.len > 32) wr(3'd1, t.w1);
            repeat (5) @(posedge clk);
            peek(3'd4, v);
            check($sformatf("R2 no start on load v%0d", i), 64'(v), 64'h0);
            check($sformatf("R2 selects idle before start v%0d", i), 64'(spi_ss), 64'(idle));
            mon_cpha = t.cpha; mon_cpol = t.cpol; mon_cnt = 0; mon_bits = '0;
            burst(ctrl_word(int'(t.len), t.cs, t.pre, t.post, 1'b1), cyc, xm, ssm);
            check($sformatf("R1 exchange bit busy v%0d", i), 64'(xm), 64'h1);
            check($sformatf("R6 select active v%0d", i), 64'(ssm), 64'(idle ^ (4'b1 << t.cs)));
            check($sformatf("R3 burst cycles v%0d", i), 64'(cyc), 64'(2 * int'(t.len) * n));
            check($sformatf("R5 sampling edges v%0d", i), 64'(mon_cnt), 64'(t.len));
            stream = (t.len > 32) ? {t.w0 & m0, t.w1} : {32'h0, t.w0 & m0};
            m64 = (t.len >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << t.len) - 1);
            check($sformatf("R4 mosi bit order v%0d", i), mon_bits & m64, stream);
            peek(3'd2, v);
            check($sformatf("R1 exchange self-clear v%0d", i), 64'(v[2]), 64'h0);
            check($sformatf("R6 selects idle after v%0d", i), 64'(spi_ss), 64'(idle));
            rd(3'd0, x0);
            check($sformatf("R7 rx first word v%0d", i), 64'(x0), 64'(t.w0 & m0));
            if (t.len > 32) begin
                rd(3'd0, x1);
                check($sformatf("R7 rx second word v%0d", i), 64'(x1), 64'(t.w1));
            end
            peek(3'd4, v); check($sformatf("R12 done held v%0d", i), 64'(v), 64'h80);
            wr(3'd4, 32'h80);
            peek(3'd4, v); check($sformatf("R8 done cleared v%0d", i), 64'(v), 64'h0);
        end

        // R9: queue runs dry mid-burst
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h1111_2222);
        burst(ctrl_word(64, 2'd0, 4'd0, 4'd0, 1'b1), cyc, xm, ssm);
        rd(3'd0, v); check("R9 loaded word", 64'(v), 64'h1111_2222);
        rd(3'd0, v); check("R9 zero fill", 64'(v), 64'h0);
        wr(3'd4, 32'hC0);

        // R11 + R8: 256 bits queued, 288-bit burst overflows the receive queue
        for (int k = 0; k < 8; k++) wr(3'd1, 32'hA000_0000 + 32'(k * 3 + 1));
        burst(ctrl_word(288, 2'd0, 4'd0, 4'd0, 1'b1), cyc, xm, ssm);
        check("R3 long burst cycles", 64'(cyc), 64'd576);
        peek(3'd4, v); check("R8 overflow flagged", 64'(v), 64'hC0);
        for (int k = 0; k < 8; k++) begin
            rd(3'd0, v);
            check($sformatf("R11 queued word %0d", k), 64'(v), 64'(32'hA000_0000 + 32'(k * 3 + 1)));
        end
        rd(3'd0, v); check("R8 dropped word absent", 64'(v), 64'h0);
        wr(3'd4, 32'h40);
        peek(3'd4, v); check("R8 clear overflow only", 64'(v), 64'h80);
        wr(3'd4, 32'h80);
        peek(3'd4, v); check("R8 clear done", 64'(v), 64'h0);

        // R10: disable empties both queues
        wr(3'd1, 32'h5555_AAAA);
        burst(ctrl_word(32, 2'd0, 4'd0, 4'd0, 1'b1), cyc, xm, ssm);
        wr(3'd4, 32'h80);
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'h0);
        wr(3'd2, 32'h3);
        rd(3'd0, v); check("R10 rx queue flushed", 64'(v), 64'h0);
        burst(ctrl_word(32, 2'd0, 4'd0, 4'd0, 1'b1), cyc, xm, ssm);
        rd(3'd0, v); check("R10 tx queue flushed", 64'(v), 64'h0);
        wr(3'd4, 32'h80);

        // R6: idle clock level follows the control register select
        wr(3'd3, 32'h0020_0000);
        wr(3'd2, 32'h3 | (32'd1 << 18));
        peek(3'd4, v);
        check("R6 idle level cs1 high", 64'(spi_sclk), 64'h1);
        wr(3'd2, 32'h3 | (32'd2 << 18));
        peek(3'd4, v);
        check("R6 idle level cs2 low", 64'(spi_sclk), 64'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule